// File: doc/BRIEF.md
# MDIO Management Controller with Background PHY Scan

This block is the register-level side of an MDIO management controller. Software sees five 32-bit words on a one-cycle register bus. These are a revision word, a control word (run switch, divider, quiescent flag), a presence bitmap, a link bitmap and a single user-access word. A serial frame engine sits below the block. Each frame it issues lasts a fixed number of bit slots, and every slot lasts divider+1 clocks. The engine presents its descriptor on the `frm_*` outputs. At the last cycle of a frame it samples the PHY answer on `phy_ack` and `phy_rdata`.

While the run switch is on, the controller scans the PHY addresses without stopping. It reads the basic status register of each address and records which addresses answer and which of them report link up. Software can also read or write any PHY register. It does this by placing a request in the user-access word with the start bit set. The request takes priority at the next frame boundary, so it waits behind at most one scan frame. The start bit drops when the frame ends. Turning the run switch off lets the frame in flight finish, then the controller reports that it is quiescent.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control word reads 0x8000_00FF: quiescent flag (bit 31) set, run switch (bit 30) clear, divider (bits 15:0) 0xFF. The presence, link and user-access words read zero.
- R2: Word index 0 reads {16'b0, major[7:0], minor[7:0]} with the default revision 1.4, giving 0x0000_0104. Writes to it have no effect.
- R3: Control word index 1: bit 30 is the run switch and bits 15:0 the divider; bit 31 is read-only. A frame occupies 64*(divider+1) clocks, and the divider in force when the frame starts applies to the whole frame.
- R4: A write to user word index 4 while its start bit (31) is clear loads the fields: bit 30 write (0 = read), bits 25:21 register, bits 20:16 PHY, bits 15:0 data. It also clears the answered flag (bit 29). If bit 31 of the written value is set, the user frame then carries exactly those fields on `frm_*`.
- R5: When a user frame ends, the start bit clears. A read sets the answered flag to `phy_ack` and loads `phy_rdata` into the data field only when `phy_ack` is 1. A write leaves the answered flag at 0.
- R6: A write to the user word while its start bit is set leaves the word unchanged.
- R7: With no user request pending, the controller issues scan reads of register 1 at PHY addresses in ascending order, wrapping from 31 to 0. At the end of each scan frame, presence bit [addr] (word 2) takes `phy_ack`. Link bit [addr] (word 3) takes `phy_rdata[2]` only when `phy_ack` is 1 and is otherwise kept.
- R8: A pending user request is served by the next frame that starts, so a scan frame already in flight delays it by no more than one frame.
- R9: With the run switch clear, no frame starts and a pending request stays pending. The quiescent flag is 1 exactly when the run switch is clear and no frame is active.
- R10: `frm_active` stays high for the whole frame. `frm_done` pulses on its last cycle, the descriptor outputs hold steady throughout, and at least one idle cycle separates frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Word index for register access |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| frm_active | output | 1 | A frame is in progress |
| frm_done | output | 1 | Last cycle of the current frame |
| frm_write | output | 1 | Current frame is a write |
| frm_phy | output | 5 | PHY address of the current frame |
| frm_reg | output | 5 | Register address of the current frame |
| frm_wdata | output | 16 | Write data of the current frame |
| phy_ack | input | 1 | PHY answered (sampled on the last frame cycle) |
| phy_rdata | input | 16 | Data read from the PHY (sampled on the last frame cycle) |

## Verification
The hardest case to reach is a user request that arrives just after a scan frame has begun, because that is the only moment where the one-frame deferral bound is tight. The bench waits for the rising edge of a scan frame on the frame outputs, posts a request in the next cycle and counts the clocks until the user frame begins. A second hard case is a PHY that disappears mid-run while its link bit was set. The bench changes its simulated PHY population and lets a full sweep complete. It then confirms that presence clears while the stale link bit stays.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int MDATA_W = 16;

  localparam logic [2:0] SEL_REVISION = 3'd0;
  localparam logic [2:0] SEL_CONTROL  = 3'd1;
  localparam logic [2:0] SEL_PRESENCE = 3'd2;
  localparam logic [2:0] SEL_LINKMAP  = 3'd3;
  localparam logic [2:0] SEL_USERWORD = 3'd4;

  localparam int CTL_QUIET_BIT = 31;
  localparam int CTL_RUN_BIT   = 30;

  localparam int UW_START_BIT = 31;
  localparam int UW_WRITE_BIT = 30;
  localparam int UW_ANS_BIT   = 29;
  localparam int UW_REG_LSB   = 21;
  localparam int UW_PHY_LSB   = 16;

  localparam logic [REG_AW-1:0] SCAN_STATUS_REG = 5'd1;
  localparam int LINK_UP_BIT = 2;

  typedef struct packed {
    logic                 is_user;
    logic                 write;
    logic [PHY_AW-1:0]    phy;
    logic [REG_AW-1:0]    regad;
    logic [MDATA_W-1:0]   wdata;
  } frame_desc_t;

  function automatic logic [31:0] pack_user_word(
    input logic               start,
    input logic               write,
    input logic               ans,
    input logic [REG_AW-1:0]  regad,
    input logic [PHY_AW-1:0]  phy,
    input logic [MDATA_W-1:0] data
  );
    logic [31:0] w;
    w = '0;
    w[UW_START_BIT] = start;
    w[UW_WRITE_BIT] = write;
    w[UW_ANS_BIT]   = ans;
    w[UW_REG_LSB +: REG_AW] = regad;
    w[UW_PHY_LSB +: PHY_AW] = phy;
    w[MDATA_W-1:0] = data;
    return w;
  endfunction

endpackage

// File: rtl/mdio_frame_timer.sv
module mdio_frame_timer
  import mdio_mgmt_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  frame_desc_t      desc_in,
  output logic             active,
  output logic             done,
  output frame_desc_t      desc_q
);

  localparam int CNT_W = DIV_W + $clog2(FRAME_BITS) + 1;

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] frame_cycles(input logic [DIV_W-1:0] d);
    return CNT_W'(FRAME_BITS) * (CNT_W'(d) + CNT_W'(1));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      desc_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= frame_cycles(div) - CNT_W'(1);
      desc_q <= desc_in;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign done = active && (cnt_q == '0);

endmodule

// File: rtl/mdio_scan_tracker.sv
module mdio_scan_tracker
  import mdio_mgmt_pkg::*;
#(
  parameter int NUM_PHY = 32,
  parameter int PTR_W   = $clog2(NUM_PHY)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_done,
  input  logic               resp_ack,
  input  logic [MDATA_W-1:0] resp_data,
  output logic [PTR_W-1:0]   ptr,
  output logic [NUM_PHY-1:0] alive,
  output logic [NUM_PHY-1:0] link
);

  function automatic logic [PTR_W-1:0] next_addr(input logic [PTR_W-1:0] a);
    return (a == PTR_W'(NUM_PHY - 1)) ? '0 : a + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr <= '0;
    else if (scan_done) ptr <= next_addr(ptr);
  end

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_slot
    logic hit;
    assign hit = scan_done && (ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alive[g] <= 1'b0;
        link[g]  <= 1'b0;
      end else if (hit) begin
        alive[g] <= resp_ack;
        if (resp_ack) link[g] <= resp_data[LINK_UP_BIT];
      end
    end
  end

endmodule

// File: rtl/mdio_user_port.sv
module mdio_user_port
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  input  logic               frame_end,
  input  logic               resp_ack,
  input  logic [MDATA_W-1:0] resp_data,
  output logic               accept,
  output logic               go,
  output logic               write,
  output logic [REG_AW-1:0]  regad,
  output logic [PHY_AW-1:0]  phy,
  output logic [MDATA_W-1:0] data,
  output logic [31:0]        word
);

  logic ans;

  assign accept = wr_en && !go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go    <= 1'b0;
      write <= 1'b0;
      ans   <= 1'b0;
      regad <= '0;
      phy   <= '0;
      data  <= '0;
    end else if (accept) begin
      go    <= wdata[UW_START_BIT];
      write <= wdata[UW_WRITE_BIT];
      ans   <= 1'b0;
      regad <= wdata[UW_REG_LSB +: REG_AW];
      phy   <= wdata[UW_PHY_LSB +: PHY_AW];
      data  <= wdata[MDATA_W-1:0];
    end else if (frame_end) begin
      go <= 1'b0;
      if (write) begin
        ans <= 1'b0;
      end else begin
        ans <= resp_ack;
        if (resp_ack) data <= resp_data;
      end
    end
  end

  assign word = pack_user_word(go, write, ans, regad, phy, data);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int              FRAME_BITS = 64,
  parameter int              DIV_W      = 16,
  parameter logic [15:0]     DIV_RESET  = 16'h00FF,
  parameter logic [7:0]      REV_MAJOR  = 8'd1,
  parameter logic [7:0]      REV_MINOR  = 8'd4,
  parameter int              NUM_PHY    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        frm_active,
  output logic        frm_done,
  output logic        frm_write,
  output logic [4:0]  frm_phy,
  output logic [4:0]  frm_reg,
  output logic [15:0] frm_wdata,
  input  logic        phy_ack,
  input  logic [15:0] phy_rdata
);

  localparam int PTR_W = $clog2(NUM_PHY);

  logic               run_q;
  logic [DIV_W-1:0]   div_q;
  logic               ctl_wr, user_wr;
  logic               start_frame;
  logic               frame_active, frame_done;
  logic               user_done, scan_done;
  logic               desc_is_user;
  logic               quiet;
  frame_desc_t        next_desc, cur_desc;

  logic               u_go, u_write, user_accept;
  logic [REG_AW-1:0]  u_reg;
  logic [PHY_AW-1:0]  u_phy;
  logic [MDATA_W-1:0] u_data;
  logic [31:0]        u_word;

  logic [PTR_W-1:0]   scan_ptr;
  logic [NUM_PHY-1:0] alive_q, link_q;

  assign ctl_wr  = reg_we && (reg_sel == SEL_CONTROL);
  assign user_wr = reg_we && (reg_sel == SEL_USERWORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= DIV_W'(DIV_RESET);
    end else if (ctl_wr) begin
      run_q <= reg_wdata[CTL_RUN_BIT];
      div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  // Arbitration: a frame starts whenever the engine is free and running;
  // a pending user request always wins that slot.
  assign start_frame = run_q && !frame_active;

  always_comb begin
    next_desc = '0;
    if (u_go) begin
      next_desc.is_user = 1'b1;
      next_desc.write   = u_write;
      next_desc.phy     = u_phy;
      next_desc.regad   = u_reg;
      next_desc.wdata   = u_data;
    end else begin
      next_desc.is_user = 1'b0;
      next_desc.write   = 1'b0;
      next_desc.phy     = PHY_AW'(scan_ptr);
      next_desc.regad   = SCAN_STATUS_REG;
      next_desc.wdata   = '0;
    end
  end

  mdio_frame_timer #(
    .FRAME_BITS (FRAME_BITS),
    .DIV_W      (DIV_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_frame),
    .div     (div_q),
    .desc_in (next_desc),
    .active  (frame_active),
    .done    (frame_done),
    .desc_q  (cur_desc)
  );

  assign desc_is_user = cur_desc.is_user;
  assign user_done    = frame_done && desc_is_user;
  assign scan_done    = frame_done && !desc_is_user;
  assign quiet        = !run_q && !frame_active;

  mdio_user_port u_user (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (user_wr),
    .wdata     (reg_wdata),
    .frame_end (user_done),
    .resp_ack  (phy_ack),
    .resp_data (phy_rdata),
    .accept    (user_accept),
    .go        (u_go),
    .write     (u_write),
    .regad     (u_reg),
    .phy       (u_phy),
    .data      (u_data),
    .word      (u_word)
  );

  mdio_scan_tracker #(
    .NUM_PHY (NUM_PHY),
    .PTR_W   (PTR_W)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_done (scan_done),
    .resp_ack  (phy_ack),
    .resp_data (phy_rdata),
    .ptr       (scan_ptr),
    .alive     (alive_q),
    .link      (link_q)
  );

  function automatic logic [31:0] pack_control(input logic q, input logic r,
                                               input logic [DIV_W-1:0] d);
    logic [31:0] w;
    w = '0;
    w[CTL_QUIET_BIT] = q;
    w[CTL_RUN_BIT]   = r;
    w[DIV_W-1:0]     = d;
    return w;
  endfunction

  always_comb begin
    case (reg_sel)
      SEL_REVISION: reg_rdata = {16'h0000, REV_MAJOR, REV_MINOR};
      SEL_CONTROL:  reg_rdata = pack_control(quiet, run_q, div_q);
      SEL_PRESENCE: reg_rdata = 32'(alive_q);
      SEL_LINKMAP:  reg_rdata = 32'(link_q);
      SEL_USERWORD: reg_rdata = u_word;
      default:      reg_rdata = '0;
    endcase
  end

  assign frm_active = frame_active;
  assign frm_done   = frame_done;
  assign frm_write  = cur_desc.write;
  assign frm_phy    = cur_desc.phy;
  assign frm_reg    = cur_desc.regad;
  assign frm_wdata  = cur_desc.wdata;

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
  parameter int NUM_PHY = 32,
  parameter int PTR_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_q,
  input logic               quiet,
  input logic               frame_active,
  input logic               frame_done,
  input logic               desc_is_user,
  input logic               user_done,
  input logic               scan_done,
  input logic               u_go,
  input logic [31:0]        u_word,
  input logic               user_wr,
  input logic [4:0]         frm_phy,
  input logic [4:0]         frm_reg,
  input logic               phy_ack,
  input logic [PTR_W-1:0]   scan_ptr,
  input logic [NUM_PHY-1:0] alive_q
);

  logic [NUM_PHY-1:0] ptr_onehot;
  assign ptr_onehot = NUM_PHY'(1) << scan_ptr;

  a_r5_start_bit_drops: assert property (@(posedge clk) disable iff (!rst_n)
    user_done |=> !u_go);

  a_r9_quiet_means_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !frame_active);

  a_r9_no_start_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> $past(run_q));

  a_r8_user_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) && $past(u_go) |-> desc_is_user);

  a_r6_busy_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    user_wr && u_go && !user_done |=> $stable(u_word));

  a_r7_presence_set_on_answer: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done && phy_ack |=> (alive_q & $past(ptr_onehot)) != '0);

  a_r7_presence_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> $countones(alive_q ^ $past(alive_q)) <= 1);

  a_r7_scan_uses_status_reg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) && !desc_is_user |-> frm_reg == 5'd1);

  a_r10_desc_steady: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active && !frame_done |=> frame_active && $stable({frm_phy, frm_reg}));

  a_r10_gap_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_active);

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(
  .NUM_PHY (NUM_PHY),
  .PTR_W   (PTR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_q        (run_q),
  .quiet        (quiet),
  .frame_active (frame_active),
  .frame_done   (frame_done),
  .desc_is_user (desc_is_user),
  .user_done    (user_done),
  .scan_done    (scan_done),
  .u_go         (u_go),
  .u_word       (u_word),
  .user_wr      (user_wr),
  .frm_phy      (frm_phy),
  .frm_reg      (frm_reg),
  .phy_ack      (phy_ack),
  .scan_ptr     (scan_ptr),
  .alive_q      (alive_q)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;

  localparam int FB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        frm_active, frm_done, frm_write;
  logic [4:0]  frm_phy, frm_reg;
  logic [15:0] frm_wdata;
  logic        phy_ack;
  logic [15:0] phy_rdata;

  logic [31:0] present = 32'hA000_0415;
  logic [31:0] link_up = 32'h2000_0011;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] phy_data(input logic [4:0] p, input logic [4:0] r);
    if (r == 5'd1) return 16'h7849 | (link_up[p] ? 16'h0004 : 16'h0000);
    return {r, 3'b101, p, 3'b010};
  endfunction

  assign phy_ack   = present[frm_phy];
  assign phy_rdata = phy_data(frm_phy, frm_reg);

  mdio_mgmt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_active(frm_active),
    .frm_done(frm_done), .frm_write(frm_write), .frm_phy(frm_phy),
    .frm_reg(frm_reg), .frm_wdata(frm_wdata), .phy_ack(phy_ack),
    .phy_rdata(phy_rdata)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_run, m_busy, m_user, m_fwr;
  int          m_div, m_left, m_ptr;
  bit          m_go, m_wr, m_ans;
  logic [4:0]  m_reg, m_phy, m_fphy, m_freg;
  logic [15:0] m_data, m_fwd;
  logic [31:0] m_alive, m_link;
  bit          t_done, t_start, t_go, t_ack;
  logic [15:0] t_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_div = 255; m_busy = 0; m_left = 0; m_ptr = 0;
      m_go = 0; m_wr = 0; m_ans = 0; m_reg = 0; m_phy = 0; m_data = 0;
      m_alive = 0; m_link = 0; m_user = 0; m_fwr = 0; m_fphy = 0; m_freg = 0; m_fwd = 0;
    end else begin
      t_done  = m_busy && (m_left == 1);
      t_start = m_run && !m_busy;
      t_go    = m_go;
      t_ack   = present[m_fphy];
      t_rd    = phy_data(m_fphy, m_freg);
      if (t_done && m_user) begin
        m_go = 0;
        if (m_wr) m_ans = 0;
        else begin m_ans = t_ack; if (t_ack) m_data = t_rd; end
      end
      if (t_done && !m_user) begin
        m_alive[m_ptr] = t_ack;
        if (t_ack) m_link[m_ptr] = t_rd[2];
        m_ptr = (m_ptr + 1) % 32;
      end
      if (t_start) begin
        m_busy = 1; m_left = FB * (m_div + 1); m_user = t_go;
        if (t_go) begin m_fphy = m_phy; m_freg = m_reg; m_fwr = m_wr; m_fwd = m_data; end
        else begin m_fphy = 5'(m_ptr); m_freg = 5'd1; m_fwr = 0; m_fwd = 0; end
      end else if (m_busy) begin
        if (m_left == 1) m_busy = 0; else m_left = m_left - 1;
      end
      if (reg_we && reg_sel == 3'd4 && !t_go) begin
        m_go = reg_wdata[31]; m_wr = reg_wdata[30]; m_ans = 0;
        m_reg = reg_wdata[25:21]; m_phy = reg_wdata[20:16]; m_data = reg_wdata[15:0];
      end
      if (reg_we && reg_sel == 3'd1) begin
        m_run = reg_wdata[30]; m_div = int'(reg_wdata[15:0]);
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [2:0] s);
    case (s)
      3'd0: return 32'h0000_0104;
      3'd1: return {(!m_run && !m_busy), m_run, 14'd0, 16'(m_div)};
      3'd2: return m_alive;
      3'd3: return m_link;
      3'd4: return {m_go, m_wr, m_ans, 3'd0, m_reg, m_phy, m_data};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model (R10 frame outputs, register view)
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check(frm_active == m_busy, "R10 model frm_active", 32'(frm_active), 32'(m_busy));
      check(frm_done == (m_busy && m_left == 1), "R10 model frm_done",
            32'(frm_done), 32'(m_busy && m_left == 1));
      if (m_busy)
        check({frm_write, frm_phy, frm_reg, frm_wdata} == {m_fwr, m_fphy, m_freg, m_fwd},
              "R10 model descriptor", 32'({frm_write, frm_phy, frm_reg, frm_wdata}),
              32'({m_fwr, m_fphy, m_freg, m_fwd}));
      check(reg_rdata == model_read(reg_sel), "R3 model register view",
            reg_rdata, model_read(reg_sel));
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_start();
    while (frm_active) @(negedge clk);
    while (!frm_active) @(negedge clk);
  endtask

  task automatic frame_len(output int n);
    n = 0;
    while (frm_active) begin n++; @(negedge clk); end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n;
    bit seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd1, v); check(v == 32'h8000_00FF, "R1 control reset", v, 32'h8000_00FF);
    rd(3'd2, v); check(v == 0, "R1 presence reset", v, 0);
    rd(3'd3, v); check(v == 0, "R1 link reset", v, 0);
    rd(3'd4, v); check(v == 0, "R1 user word reset", v, 0);
    rd(3'd0, v); check(v == 32'h0000_0104, "R2 revision", v, 32'h0000_0104);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check(v == 32'h0000_0104, "R2 revision write ignored", v, 32'h0000_0104);

    // R9: request while stopped stays pending
    wr(3'd4, 32'h8060_0000);
    repeat (20) @(negedge clk);
    rd(3'd4, v); check(v == 32'h8060_0000, "R9 request held while stopped", v, 32'h8060_0000);
    check(!frm_active, "R9 no frame while stopped", 32'(frm_active), 0);
    rd(3'd1, v); check(v[31] == 1'b1, "R9 quiet while stopped", v, 32'h8000_00FF);
    // R6: overwrite attempt while start bit set
    wr(3'd4, 32'h4000_FFFF);
    rd(3'd4, v); check(v == 32'h8060_0000, "R6 busy write ignored", v, 32'h8060_0000);

    // run with divider 0: pending user read goes first
    wr(3'd1, 32'h4000_0000);
    wait_start();
    check(frm_reg == 5'd3 && frm_phy == 5'd0 && !frm_write, "R4 user read descriptor",
          32'({frm_write, frm_phy, frm_reg}), 32'(5'd3));
    frame_len(n); check(n == 64, "R3 frame length div0", n, 64);
    rd(3'd4, v); check(v == 32'h2060_1D02, "R5 read result", v, 32'h2060_1D02);

    // R7: full sweep
    repeat (2200) @(negedge clk);
    rd(3'd2, v); check(v == 32'hA000_0415, "R7 presence map", v, 32'hA000_0415);
    rd(3'd3, v); check(v == 32'h2000_0011, "R7 link map", v, 32'h2000_0011);

    // R8: request right after a scan frame begins
    wait_start();
    check(frm_reg == 5'd1, "R7 scan frame reads status", 32'(frm_reg), 1);
    wr(3'd4, 32'hC125_BEEF);
    n = 1;
    while (!(frm_active && frm_reg == 5'd9)) begin n++; @(negedge clk); end
    check(n <= FB + 3, "R8 deferral bounded", n, FB + 3);
    check(frm_write && frm_phy == 5'd5 && frm_wdata == 16'hBEEF, "R4 user write descriptor",
          32'({frm_write, frm_phy, frm_wdata}), 32'({1'b1, 5'd5, 16'hBEEF}));
    frame_len(n);
    rd(3'd4, v); check(v == 32'h4125_BEEF, "R5 write completion", v, 32'h4125_BEEF);

    // R5: read of absent PHY keeps data, answered flag clear
    wr(3'd4, 32'h8046_1234);
    while (!(frm_active && frm_reg == 5'd2)) @(negedge clk);
    frame_len(n);
    rd(3'd4, v); check(v == 32'h0046_1234, "R5 no answer", v, 32'h0046_1234);

    // R3: divider change applies to the next frame
    wr(3'd1, 32'h4000_0001);
    wait_start();
    frame_len(n); check(n == 128, "R3 frame length div1", n, 128);

    // R7: PHY 4 disappears; link bit kept
    present = 32'hA000_0405;
    repeat (4400) @(negedge clk);
    rd(3'd2, v); check(v == 32'hA000_0405, "R7 presence cleared", v, 32'hA000_0405);
    rd(3'd3, v); check(v == 32'h2000_0011, "R7 stale link kept", v, 32'h2000_0011);

    // R9: stop mid-frame
    wait_start();
    wr(3'd1, 32'h0000_0001);
    rd(3'd1, v); check(v == 32'h0000_0001, "R9 not quiet mid-frame", v, 32'h0000_0001);
    while (frm_active) @(negedge clk);
    rd(3'd1, v); check(v == 32'h8000_0001, "R9 quiet after drain", v, 32'h8000_0001);
    seen = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (frm_active) seen = 1; end
    check(!seen, "R9 no frame after stop", 32'(seen), 0);

    summary();
  end

endmodule